// File: doc/BRIEF.md
# Parity Word-to-Symbol Repacking FIFO

This block sits between a 16-bit register bus and a consumer that takes 10-bit symbols. Software writes the eight 10-bit parity symbols of a codeword as five 16-bit words through a data register. The words are packed with the first word in the least significant position. Symbol k is bits [10k+9:10k] of the resulting 80-bit vector.

Software starts the transfer by setting a feed bit in the control register. The block then presents the eight symbols on the symbol port on eight consecutive cycles, in order from symbol 0 to symbol 7. There is no handshake: the consumer takes one symbol on every cycle in which `sym_valid` is high.

The data register address is shared with a separate read-only output FIFO that lies outside this block. A bus write to that address stores a word in the input buffer. A bus read of that address passes the output FIFO's word through and pops that FIFO for the read cycle. Status for the input side reports:
- the number of words held,
- a busy flag,
- a sticky overflow flag,
- a sticky underrun flag.

Top module: `parity_repack_fifo`

## Requirements
- R1: After reset the status word reads zero and `sym_valid` is low.
- R2: A bus write to address 0 (data) while fewer than five words are held stores the word in the next free slot. The word count in status bits [6:4] rises by one on the following cycle.
- R3: A data write while five words are held is dropped, and the sticky overflow flag (status bit 1) is set. The flag stays set until a clear.
- R4: A control write (address 1) with bit 0 (feed) set, while five words are held and no stream is running, starts a stream. `sym_valid` is high for eight consecutive cycles, beginning the cycle after the write. On the k-th of these cycles, `sym_data` equals bits [10k+9:10k] of the five words concatenated with word 0 lowest.
- R5: Status bit 0 (busy) reads 1 on every streaming cycle. The cycle after the eighth symbol, busy reads 0 and the word count reads 0.
- R6: A feed request while fewer than five words are held starts no stream, leaves the word count unchanged, and sets the sticky underrun flag (status bit 2).
- R7: A control write with bit 1 (clear) set empties the buffer, clears both sticky flags and aborts any running stream from the next cycle. If clear and feed are set in the same write, clear wins.
- R8: A bus read of address 0 returns `ofifo_rdata` on `rdata` and drives `ofifo_pop` high in that same cycle only. A data write never pops the output FIFO.
- R9: A bus read of address 1 returns the status word (bit 0 busy, bit 1 overflow, bit 2 underrun, bits [6:4] word count, all other bits 0). It does not pop the output FIFO.
- R10: A feed request during a running stream is ignored. The stream completes unchanged and does not restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register select: 0 data, 1 control/status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational from address) |
| ofifo_rdata | input | 16 | Head word of the external output FIFO |
| ofifo_pop | output | 1 | Pop strobe to the external output FIFO |
| sym_valid | output | 1 | Symbol valid, one symbol per cycle |
| sym_data | output | 10 | Parity symbol |

## Verification
Read data and `ofifo_pop` are combinational from the bus strobes, so they are sampled in the same cycle as the read, one time unit after the inputs settle. Effects of a write appear one clock edge later. The word count shows up on the next cycle's status read. The first symbol is due on the cycle right after the feed write's edge, and symbol k follows k cycles later. Busy and the word count return to zero on the cycle after symbol 7. The bench drives every input on the falling edge and checks symbols one per falling edge, counted from the feed write. Each check therefore falls in the exact cycle in which its result is due, and an early or late symbol is caught as a miscompare.

// File: rtl/prf_pkg.sv
package prf_pkg;
  typedef enum logic {
    REG_DATA = 1'b0,
    REG_CTRL = 1'b1
  } reg_sel_e;

  localparam int CTRL_FEED_BIT = 0;
  localparam int CTRL_CLR_BIT  = 1;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_OVF_BIT  = 1;
  localparam int STAT_UNR_BIT  = 2;
  localparam int STAT_CNT_LSB  = 4;
endpackage

// File: rtl/prf_reg_port.sv
module prf_reg_port
  import prf_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [1:0]        ctrl_bits,
  input  logic [WORD_W-1:0] ofifo_rdata,
  input  logic              busy,
  input  logic              ovf_flag,
  input  logic              unr_flag,
  input  logic [CNT_W-1:0]  word_cnt,
  output logic              data_wr,
  output logic              feed_req,
  output logic              clr_req,
  output logic              ofifo_pop,
  output logic [WORD_W-1:0] bus_rdata
);
  reg_sel_e sel;
  logic     ctrl_wr;

  assign sel     = reg_sel_e'(bus_addr);
  assign data_wr = bus_wr && (sel == REG_DATA);
  assign ctrl_wr = bus_wr && (sel == REG_CTRL);

  // clear dominates feed when both arrive in one write
  assign clr_req  = ctrl_wr && ctrl_bits[CTRL_CLR_BIT];
  assign feed_req = ctrl_wr && ctrl_bits[CTRL_FEED_BIT] && !ctrl_bits[CTRL_CLR_BIT];

  assign ofifo_pop = bus_rd && (sel == REG_DATA);

  always_comb begin
    bus_rdata = '0;
    if (sel == REG_DATA) begin
      bus_rdata = ofifo_rdata;
    end else begin
      bus_rdata[STAT_BUSY_BIT]             = busy;
      bus_rdata[STAT_OVF_BIT]              = ovf_flag;
      bus_rdata[STAT_UNR_BIT]              = unr_flag;
      bus_rdata[STAT_CNT_LSB +: CNT_W]     = word_cnt;
    end
  end
endmodule

// File: rtl/prf_word_store.sv
module prf_word_store #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned CNT_W     = $clog2(NUM_WORDS + 1),
  parameter int unsigned PACK_W    = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              flush,
  input  logic              clr_flags,
  output logic [PACK_W-1:0] pack,
  output logic [CNT_W-1:0]  word_cnt,
  output logic              full,
  output logic              ovf_flag
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NUM_WORDS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             accept;

  assign full     = (cnt_q == CNT_FULL);
  assign accept   = data_wr && !full;
  assign word_cnt = cnt_q;
  assign ovf_flag = ovf_q;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (data_wr) begin
      if (full) ovf_d = 1'b1;
      else      cnt_d = cnt_q + 1'b1;
    end
    if (flush)     cnt_d = '0;
    if (clr_flags) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_slot
    logic [WORD_W-1:0] word_q;
    logic              slot_en;

    assign slot_en = accept && (cnt_q == CNT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (slot_en) word_q <= wdata;
    end

    assign pack[i*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/prf_symbol_seq.sv
module prf_symbol_seq #(
  parameter int unsigned SYM_W    = 10,
  parameter int unsigned NUM_SYMS = 8,
  parameter int unsigned PACK_W   = 80,
  parameter int unsigned IDX_W    = (NUM_SYMS > 1) ? $clog2(NUM_SYMS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feed_req,
  input  logic              abort,
  input  logic              full,
  input  logic [PACK_W-1:0] pack,
  output logic              busy,
  output logic              done,
  output logic              unr_flag,
  output logic              sym_valid,
  output logic [SYM_W-1:0]  sym_data
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_SYMS - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             unr_q, unr_d;
  logic [SYM_W-1:0] sym_tab [NUM_SYMS];

  for (genvar k = 0; k < NUM_SYMS; k++) begin : g_sym
    assign sym_tab[k] = pack[k*SYM_W +: SYM_W];
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    unr_d  = unr_q;
    done   = 1'b0;
    if (busy_q) begin
      if (idx_q == IDX_LAST) begin
        busy_d = 1'b0;
        idx_d  = '0;
        done   = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else if (feed_req) begin
      if (full) begin
        busy_d = 1'b1;
        idx_d  = '0;
      end else begin
        unr_d = 1'b1;
      end
    end
    if (abort) begin
      busy_d = 1'b0;
      idx_d  = '0;
      unr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      unr_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      unr_q  <= unr_d;
    end
  end

  assign busy      = busy_q;
  assign unr_flag  = unr_q;
  assign sym_valid = busy_q;
  assign sym_data  = busy_q ? sym_tab[idx_q] : '0;
endmodule

// File: rtl/parity_repack_fifo.sv
module parity_repack_fifo #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SYM_W     = 10,
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned NUM_SYMS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] ofifo_rdata,
  output logic              ofifo_pop,
  output logic              sym_valid,
  output logic [SYM_W-1:0]  sym_data
);
  localparam int unsigned PACK_W = WORD_W * NUM_WORDS;
  localparam int unsigned CNT_W  = $clog2(NUM_WORDS + 1);
  localparam int unsigned IDX_W  = (NUM_SYMS > 1) ? $clog2(NUM_SYMS) : 1;

  if (SYM_W * NUM_SYMS > PACK_W) begin : g_bad_geometry
    initial $error("symbols exceed buffered bits");
  end

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              data_wr, feed_req, clr_req;
  logic              busy, done, ovf_flag, unr_flag, full;
  logic [CNT_W-1:0]  word_cnt;
  logic [PACK_W-1:0] pack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  prf_reg_port #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_port (
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .ctrl_bits   (bus_wdata[1:0]),
    .ofifo_rdata (ofifo_rdata),
    .busy        (busy),
    .ovf_flag    (ovf_flag),
    .unr_flag    (unr_flag),
    .word_cnt    (word_cnt),
    .data_wr     (data_wr),
    .feed_req    (feed_req),
    .clr_req     (clr_req),
    .ofifo_pop   (ofifo_pop),
    .bus_rdata   (bus_rdata)
  );

  prf_word_store #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CNT_W(CNT_W), .PACK_W(PACK_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .data_wr   (data_wr),
    .wdata     (bus_wdata),
    .flush     (done || clr_req),
    .clr_flags (clr_req),
    .pack      (pack),
    .word_cnt  (word_cnt),
    .full      (full),
    .ovf_flag  (ovf_flag)
  );

  prf_symbol_seq #(
    .SYM_W(SYM_W), .NUM_SYMS(NUM_SYMS), .PACK_W(PACK_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .feed_req  (feed_req),
    .abort     (clr_req),
    .full      (full),
    .pack      (pack),
    .busy      (busy),
    .done      (done),
    .unr_flag  (unr_flag),
    .sym_valid (sym_valid),
    .sym_data  (sym_data)
  );
endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned NUM_SYMS  = 8,
  parameter int unsigned CNT_W     = $clog2(NUM_WORDS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [WORD_W-1:0] ofifo_rdata,
  input logic              ofifo_pop,
  input logic              sym_valid,
  input logic              ovf_flag,
  input logic              clr_req,
  input logic [CNT_W-1:0]  word_cnt
);
  localparam int unsigned RUN_W = $clog2(NUM_SYMS + 1) + 1;
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= '0;
    else if (sym_valid) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt <= CNT_W'(NUM_WORDS));

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_req) |=> ovf_flag);

  // R4
  feed_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sym_valid) |-> ($past(word_cnt) == CNT_W'(NUM_WORDS)));

  // R5
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (run_len < RUN_W'(NUM_SYMS)));

  // R5
  flush_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sym_valid) |-> (word_cnt == '0));

  // R8
  pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ofifo_pop |-> (bus_rd && !bus_wr && bus_rdata == ofifo_rdata));
endmodule

bind parity_repack_fifo prf_checker #(
  .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NUM_SYMS(NUM_SYMS), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_rdata   (bus_rdata),
  .ofifo_rdata (ofifo_rdata),
  .ofifo_pop   (ofifo_pop),
  .sym_valid   (sym_valid),
  .ovf_flag    (ovf_flag),
  .clr_req     (clr_req),
  .word_cnt    (word_cnt)
);

// File: tb/parity_repack_fifo_test.sv
module parity_repack_fifo_test;
  logic        clk, rst_n;
  logic        bus_wr, bus_rd, bus_addr;
  logic [15:0] bus_wdata, bus_rdata, ofifo_rdata;
  logic        ofifo_pop, sym_valid;
  logic [9:0]  sym_data;

  int nvec, nfail;
  bit finished;
  logic wr_pop_seen;

  localparam logic [79:0] PACKS [4] = '{
    80'h0123_4567_89AB_CDEF_FEDC,
    80'hFFFF_0000_FFFF_0000_FFFF,
    80'hA5A5_5A5A_3C3C_C3C3_0F0F,
    80'h8000_0001_7FFE_1234_ABCD
  };

  parity_repack_fifo uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ofifo_rdata(ofifo_rdata), .ofifo_pop(ofifo_pop),
    .sym_valid(sym_valid), .sym_data(sym_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1 wr_pop_seen = ofifo_pop;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic a, output logic [15:0] d, output logic p);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata; p = ofifo_pop;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [15:0] stat(input logic busy, input logic ovf,
                                       input logic unr, input logic [2:0] cnt);
    return {9'd0, cnt, 1'b0, unr, ovf, busy};
  endfunction

  task automatic load_pack(input logic [79:0] p);
    for (int i = 0; i < 5; i++) bus_write(1'b1 ^ 1'b1, p[i*16 +: 16]);
  endtask

  // Called right after the feed write returns: symbol 0 is due now.
  task automatic stream_check(input logic [79:0] p, input logic ovf, input string tag);
    logic [15:0] st; logic pp;
    for (int k = 0; k < 8; k++) begin
      check({tag, " R4 valid"}, 32'(sym_valid), 32'd1);
      check({tag, " R4 symbol"}, 32'(sym_data), 32'(p[k*10 +: 10]));
      bus_read(1'b1, st, pp);
      check({tag, " R5 busy"}, 32'(st[0]), 32'd1);
    end
    check({tag, " R5 end valid"}, 32'(sym_valid), 32'd0);
    bus_read(1'b1, st, pp);
    check({tag, " R5 end status"}, 32'(st), 32'(stat(1'b0, ovf, 1'b0, 3'd0)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nvec++; nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] st; logic pp;
    nvec = 0; nfail = 0; finished = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 1'b0;
    bus_wdata = '0; ofifo_rdata = 16'hA5C3; wr_pop_seen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 valid", 32'(sym_valid), 32'd0);
    bus_read(1'b1, st, pp);
    check("R1 status", 32'(st), 32'd0);

    // Vector table: each pack loaded, fed and streamed out
    for (int v = 0; v < 4; v++) begin
      bus_write(1'b1, 16'h0002);
      load_pack(PACKS[v]);
      bus_read(1'b1, st, pp);
      check("R2 full count", 32'(st), 32'(stat(1'b0, 1'b0, 1'b0, 3'd5)));
      bus_write(1'b1, 16'h0001);
      stream_check(PACKS[v], 1'b0, "table");
    end

    // R2 partial fill
    bus_write(1'b0, 16'h1111);
    check("R8 write no pop", 32'(wr_pop_seen), 32'd0);
    bus_write(1'b0, 16'h2222);
    bus_read(1'b1, st, pp);
    check("R2 count two", 32'(st), 32'(stat(1'b0, 1'b0, 1'b0, 3'd2)));
    check("R9 no pop", 32'(pp), 32'd0);

    // R6 underrun
    bus_write(1'b1, 16'h0001);
    check("R6 no stream", 32'(sym_valid), 32'd0);
    bus_read(1'b1, st, pp);
    check("R6 status", 32'(st), 32'(stat(1'b0, 1'b0, 1'b1, 3'd2)));

    // R7 clear
    bus_write(1'b1, 16'h0002);
    bus_read(1'b1, st, pp);
    check("R7 cleared", 32'(st), 32'd0);

    // R3 overflow: sixth word dropped, flag sticky through a stream
    load_pack(PACKS[2]);
    bus_write(1'b0, 16'hDEAD);
    bus_read(1'b1, st, pp);
    check("R3 status", 32'(st), 32'(stat(1'b0, 1'b1, 1'b0, 3'd5)));
    bus_write(1'b1, 16'h0001);
    stream_check(PACKS[2], 1'b1, "R3 dropped");

    // R10 feed during stream ignored
    bus_write(1'b1, 16'h0002);
    load_pack(PACKS[3]);
    bus_write(1'b1, 16'h0001);
    for (int k = 0; k < 8; k++) begin
      check("R10 valid", 32'(sym_valid), 32'd1);
      check("R10 symbol", 32'(sym_data), 32'(PACKS[3][k*10 +: 10]));
      if (k == 2) bus_write(1'b1, 16'h0001);
      else @(negedge clk);
    end
    check("R10 stopped", 32'(sym_valid), 32'd0);
    @(negedge clk);
    check("R10 no restart", 32'(sym_valid), 32'd0);

    // R7 abort mid-stream
    load_pack(PACKS[1]);
    bus_write(1'b1, 16'h0001);
    @(negedge clk); @(negedge clk);
    bus_write(1'b1, 16'h0002);
    check("R7 abort valid", 32'(sym_valid), 32'd0);
    bus_read(1'b1, st, pp);
    check("R7 abort status", 32'(st), 32'd0);

    // R7 clear wins over feed
    load_pack(PACKS[0]);
    bus_write(1'b1, 16'h0003);
    check("R7 clear wins valid", 32'(sym_valid), 32'd0);
    bus_read(1'b1, st, pp);
    check("R7 clear wins status", 32'(st), 32'd0);

    // R8 shared address read
    ofifo_rdata = 16'h5A3C;
    bus_read(1'b0, st, pp);
    check("R8 data", 32'(st), 32'h5A3C);
    check("R8 pop", 32'(pp), 32'd1);
    #1 check("R8 pop one cycle", 32'(ofifo_pop), 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule